// File: doc/BRIEF.md
# Configuration Access PIO Engine

This block lets a host CPU issue configuration reads and writes toward a PCIe link layer, one at a time, by programming registers. Software writes a control word that selects the access kind, a 64-bit target address split into two words, write data and a byte-lane strobe. Writing 1 to the start register launches the access. The engine sends a one-cycle request on a simple request port and then waits for a completion. It records the completion status, captures read data, drops the start flag and sets a done bit. The done bit also drives the interrupt output.

Software uses the engine by polling. It clears start and done, programs the access, sets start, then waits until start reads 0 and done reads 1. If no completion arrives within a parameterised cycle budget, the engine ends the access as an abort. A control word with an unknown access kind is never sent; it is reported as an unsupported request.

Top module: `cfg_pio_engine`

## Requirements
- R1: After reset every register reads 0, req_valid_o is 0 and irq_o is 0.
- R2: The register map uses byte offsets, and any other offset reads 0:
  - 0x00 control: bits 3:0 access kind, bit 24 window-bypass flag; all other bits read 0.
  - 0x04 status: read only.
  - 0x08 address low.
  - 0x0C address high.
  - 0x10 write data.
  - 0x14 strobe: bits 3:0.
  - 0x18 read data: read only.
  - 0x1C start: bit 0.
  - 0x20 done: bit 0, write 1 to clear.
- R3: In idle, writing 1 to start with a valid kind raises req_valid_o for exactly one cycle. It rises in the cycle after the clock edge that follows the start write. The request carries:
  - req_write_o = kind bit 1.
  - req_type1_o = kind bit 0.
  - req_addr_o = {high, low}.
  - req_wdata_o = the write data.
  - req_bypass_o = control bit 24.
- R4: For writes (kinds 0xA and 0xB), req_strb_o carries the programmed strobe. For reads (kinds 0x8 and 0x9) it is 4'hF. A sub-dword write at byte offset o of size s uses the strobe ((1<<s)-1)<<o, with the data shifted left by 8*o.
- R5: On a completion, the engine does the following:
  - Status bits 9:7 take the completion code (0 ok, 1 unsupported, 2 retry, 4 abort).
  - Status bit 0 is set to mark the access non-posted.
  - Start reads 0 and done reads 1.
  - irq_o follows done.
  - A read with code 0 loads the completion data into read data.
- R6: A read that completes with a non-zero code loads 32'hFFFF_FFFF into read data and still sets done.
- R7: A write access leaves the read-data register unchanged.
- R8: If no completion arrives in TIMEOUT_CYCLES cycles after the request cycle, the access ends with code 4. A read then loads all-ones into read data. Start falls at the edge TIMEOUT_CYCLES+2 edges after the start write.
- R9: A start with a kind whose bits 3:2 are not 2'b10 issues no request. It ends on the next edge with code 1. If kind bit 1 is 0, read data becomes all-ones.
- R10: While start reads 1, writes to control, address, write data, strobe and start are ignored, and no further request is issued.
- R11: Writing 1 to bit 0 of done clears it and irq_o. Writing 0 there has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | REG_AW | Register byte address |
| reg_we_i | input | 1 | Register write enable |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, same cycle |
| req_valid_o | output | 1 | One-cycle request strobe |
| req_write_o | output | 1 | Request is a write |
| req_type1_o | output | 1 | Request is a type-1 configuration access |
| req_bypass_o | output | 1 | Window-bypass flag |
| req_addr_o | output | 64 | Target address |
| req_wdata_o | output | 32 | Write data |
| req_strb_o | output | 4 | Byte-lane strobe |
| cpl_valid_i | input | 1 | Completion strobe |
| cpl_status_i | input | 3 | Completion code |
| cpl_data_i | input | 32 | Completion data |
| irq_o | output | 1 | Done interrupt |

## Verification
The bench builds the engine with TIMEOUT_CYCLES set to 40 instead of the large default. This brings the abort path within a few dozen cycles, so the exact edge at which start falls after a silent link can be checked. A completer stub answers with a random latency of one to eight cycles and a random code. Together with the short budget, every completion code, every access kind and the busy window can be exercised alongside the timeout case.

// File: rtl/cfg_pio_pkg.sv
package cfg_pio_pkg;
  localparam int unsigned REG_AW = 6;

  localparam logic [REG_AW-1:0] OFF_CTRL  = 6'h00;
  localparam logic [REG_AW-1:0] OFF_STAT  = 6'h04;
  localparam logic [REG_AW-1:0] OFF_ALO   = 6'h08;
  localparam logic [REG_AW-1:0] OFF_AHI   = 6'h0C;
  localparam logic [REG_AW-1:0] OFF_WDAT  = 6'h10;
  localparam logic [REG_AW-1:0] OFF_STRB  = 6'h14;
  localparam logic [REG_AW-1:0] OFF_RDAT  = 6'h18;
  localparam logic [REG_AW-1:0] OFF_START = 6'h1C;
  localparam logic [REG_AW-1:0] OFF_DONE  = 6'h20;

  localparam logic [2:0] CODE_OK  = 3'd0;
  localparam logic [2:0] CODE_UR  = 3'd1;
  localparam logic [2:0] CODE_CRS = 3'd2;
  localparam logic [2:0] CODE_CA  = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} seq_state_e;
endpackage

// File: rtl/cfg_pio_regs.sv
module cfg_pio_regs
  import cfg_pio_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic              fin_i,
  input  logic [2:0]        fin_code_i,
  input  logic [DW-1:0]     fin_data_i,
  input  logic              fin_rd_i,
  output logic              start_o,
  output logic              done_o,
  output logic [3:0]        kind_o,
  output logic              bypass_o,
  output logic [2*DW-1:0]   addr_o,
  output logic [DW-1:0]     wdata_o,
  output logic [3:0]        strb_o
);
  logic [3:0]    kind_q;
  logic          byp_q;
  logic [DW-1:0] alo_q, ahi_q, wdat_q, rdat_q;
  logic [3:0]    strb_q;
  logic [2:0]    code_q;
  logic          np_q, start_q, done_q;
  logic          cfg_we;

  // configuration is frozen while an access is in flight
  assign cfg_we = reg_we_i && !start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q  <= '0;
      byp_q   <= 1'b0;
      alo_q   <= '0;
      ahi_q   <= '0;
      wdat_q  <= '0;
      strb_q  <= '0;
      rdat_q  <= '0;
      code_q  <= CODE_OK;
      np_q    <= 1'b0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (cfg_we) begin
        unique case (reg_addr_i)
          OFF_CTRL: begin
            kind_q <= reg_wdata_i[3:0];
            byp_q  <= reg_wdata_i[24];
          end
          OFF_ALO:   alo_q   <= reg_wdata_i;
          OFF_AHI:   ahi_q   <= reg_wdata_i;
          OFF_WDAT:  wdat_q  <= reg_wdata_i;
          OFF_STRB:  strb_q  <= reg_wdata_i[3:0];
          OFF_START: start_q <= reg_wdata_i[0];
          default: ;
        endcase
      end
      if (reg_we_i && reg_addr_i == OFF_DONE && reg_wdata_i[0]) done_q <= 1'b0;
      if (fin_i) begin
        start_q <= 1'b0;
        done_q  <= 1'b1;
        code_q  <= fin_code_i;
        np_q    <= 1'b1;
        if (fin_rd_i) rdat_q <= fin_data_i;
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFF_CTRL:  begin reg_rdata_o[3:0] = kind_q; reg_rdata_o[24] = byp_q; end
      OFF_STAT:  begin reg_rdata_o[9:7] = code_q; reg_rdata_o[0] = np_q; end
      OFF_ALO:   reg_rdata_o = alo_q;
      OFF_AHI:   reg_rdata_o = ahi_q;
      OFF_WDAT:  reg_rdata_o = wdat_q;
      OFF_STRB:  reg_rdata_o[3:0] = strb_q;
      OFF_RDAT:  reg_rdata_o = rdat_q;
      OFF_START: reg_rdata_o[0] = start_q;
      OFF_DONE:  reg_rdata_o[0] = done_q;
      default: ;
    endcase
  end

  assign start_o  = start_q;
  assign done_o   = done_q;
  assign kind_o   = kind_q;
  assign bypass_o = byp_q;
  assign addr_o   = {ahi_q, alo_q};
  assign wdata_o  = wdat_q;
  assign strb_o   = strb_q;

  p_done_after_fin_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_i |=> done_q && !start_q);
  p_cfg_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q && !fin_i |=> $stable(alo_q) && $stable(ahi_q) && $stable(kind_q) && $stable(strb_q));
endmodule

// File: rtl/cfg_pio_seq.sv
module cfg_pio_seq
  import cfg_pio_pkg::*;
#(
  parameter int unsigned DW             = 32,
  parameter int unsigned TIMEOUT_CYCLES = 200000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [3:0]    kind_i,
  input  logic          cpl_valid_i,
  input  logic [2:0]    cpl_status_i,
  input  logic [DW-1:0] cpl_data_i,
  output logic          req_valid_o,
  output logic          fin_o,
  output logic [2:0]    fin_code_o,
  output logic [DW-1:0] fin_data_o,
  output logic          fin_rd_o
);
  localparam int unsigned CW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT_CYCLES - 1);

  seq_state_e state_q;
  logic [CW-1:0] cnt_q;
  logic kind_ok;

  assign kind_ok  = kind_i[3:2] == 2'b10;
  assign fin_rd_o = !kind_i[1];

  always_comb begin
    fin_o      = 1'b0;
    fin_code_o = CODE_OK;
    fin_data_o = '1;
    unique case (state_q)
      S_IDLE: if (start_i && !kind_ok) begin
        fin_o      = 1'b1;
        fin_code_o = CODE_UR;
      end
      S_WAIT: if (cpl_valid_i) begin
        fin_o      = 1'b1;
        fin_code_o = cpl_status_i;
        if (cpl_status_i == CODE_OK) fin_data_o = cpl_data_i;
      end else if (cnt_q == CNT_LAST) begin
        fin_o      = 1'b1;
        fin_code_o = CODE_CA;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE:  if (start_i && kind_ok) state_q <= S_ISSUE;
        S_ISSUE: begin
          state_q <= S_WAIT;
          cnt_q   <= '0;
        end
        S_WAIT: begin
          if (fin_o) state_q <= S_IDLE;
          else       cnt_q   <= cnt_q + 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_valid_o = state_q == S_ISSUE;

  p_req_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |=> !req_valid_o);
  p_req_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> start_i);
  p_req_kind_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> kind_i[3:2] == 2'b10);
  p_wait_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_WAIT |-> cnt_q <= CNT_LAST);
endmodule

// File: rtl/cfg_pio_engine.sv
module cfg_pio_engine
  import cfg_pio_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 200000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              req_valid_o,
  output logic              req_write_o,
  output logic              req_type1_o,
  output logic              req_bypass_o,
  output logic [63:0]       req_addr_o,
  output logic [31:0]       req_wdata_o,
  output logic [3:0]        req_strb_o,
  input  logic              cpl_valid_i,
  input  logic [2:0]        cpl_status_i,
  input  logic [31:0]       cpl_data_i,
  output logic              irq_o
);
  localparam int unsigned DW = 32;

  logic          start, fin, fin_rd;
  logic [2:0]    fin_code;
  logic [DW-1:0] fin_data;
  logic [3:0]    kind, strb;

  cfg_pio_regs #(.DW(DW)) u_regs (
    .clk_i, .rst_ni, .reg_addr_i, .reg_we_i, .reg_wdata_i, .reg_rdata_o,
    .fin_i(fin), .fin_code_i(fin_code), .fin_data_i(fin_data), .fin_rd_i(fin_rd),
    .start_o(start), .done_o(irq_o), .kind_o(kind), .bypass_o(req_bypass_o),
    .addr_o(req_addr_o), .wdata_o(req_wdata_o), .strb_o(strb)
  );

  cfg_pio_seq #(.DW(DW), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_seq (
    .clk_i, .rst_ni, .start_i(start), .kind_i(kind),
    .cpl_valid_i, .cpl_status_i, .cpl_data_i,
    .req_valid_o, .fin_o(fin), .fin_code_o(fin_code), .fin_data_o(fin_data),
    .fin_rd_o(fin_rd)
  );

  assign req_write_o = kind[1];
  assign req_type1_o = kind[0];
  assign req_strb_o  = kind[1] ? strb : 4'hF;

  p_irq_on_fin_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin |=> irq_o);
endmodule

// File: tb/cfg_pio_engine_tb_top.sv
`timescale 1ns/1ps
module cfg_pio_engine_tb_top;
  localparam int TO = 40;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [5:0] reg_addr_i = '0;
  logic reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic req_valid_o, req_write_o, req_type1_o, req_bypass_o;
  logic [63:0] req_addr_o;
  logic [31:0] req_wdata_o;
  logic [3:0] req_strb_o;
  logic cpl_valid_i = 1'b0;
  logic [2:0] cpl_status_i = '0;
  logic [31:0] cpl_data_i = '0;
  logic irq_o;

  always #2.5 clk_i = ~clk_i;

  cfg_pio_engine #(.TIMEOUT_CYCLES(TO)) dut_i (.*);

  int checks = 0, errors = 0;
  int req_cnt = 0;
  int stub_lat = 0, stub_cnt = 0;
  logic [2:0] stub_code = '0;
  logic [31:0] stub_data = '0;
  logic cap_w, cap_t1, cap_b;
  logic [63:0] cap_a;
  logic [31:0] cap_d;
  logic [3:0] cap_s;
  logic [31:0] model_rdata = '0;

  // completer stub
  always @(posedge clk_i) begin
    cpl_valid_i <= 1'b0;
    if (stub_cnt == 1) begin
      cpl_valid_i <= 1'b1;
      cpl_status_i <= stub_code;
      cpl_data_i <= stub_data;
    end
    if (stub_cnt > 0) stub_cnt <= stub_cnt - 1;
    if (rst_ni && req_valid_o) begin
      req_cnt <= req_cnt + 1;
      cap_w <= req_write_o; cap_t1 <= req_type1_o; cap_b <= req_bypass_o;
      cap_a <= req_addr_o; cap_d <= req_wdata_o; cap_s <= req_strb_o;
      if (stub_lat > 0) stub_cnt <= stub_lat;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #0.5;
    d = reg_rdata_o;
  endtask

  function automatic logic [31:0] cfg_addr(logic [7:0] b, logic [4:0] dv, logic [2:0] f, logic [11:0] r);
    return {4'h0, b, dv, f, r[11:2], 2'b00};
  endfunction

  function automatic logic [3:0] lane_strb(int off, int sz);
    return 4'(((1 << sz) - 1) << off);
  endfunction

  // full access with checks; lat==0 means no completion
  task automatic access(logic [3:0] kind, logic byp, logic [31:0] alo, logic [31:0] ahi,
                        logic [31:0] wd, logic [3:0] sb, int lat, logic [2:0] code, logic [31:0] cd);
    logic [31:0] v;
    int n0;
    bit valid, is_rd;
    logic [2:0] ecode;
    valid = kind[3:2] == 2'b10;
    is_rd = !kind[1];
    stub_lat = lat; stub_code = code; stub_data = cd;
    wr(6'h1C, 0);
    wr(6'h20, 1);
    wr(6'h00, {7'b0, byp, 20'b0, kind});
    wr(6'h08, alo);
    wr(6'h0C, ahi);
    wr(6'h10, wd);
    wr(6'h14, {28'b0, sb});
    n0 = req_cnt;
    wr(6'h1C, 1);
    if (valid) begin
      @(negedge clk_i);
      chk("R3 req_valid timing", req_valid_o, 1);
    end
    for (int i = 0; i < TO + 20; i++) begin
      rd(6'h1C, v);
      if (v[0] == 1'b0) break;
      @(negedge clk_i);
    end
    chk("R5 start cleared", v, 0);
    chk("R3 R9 request count", req_cnt - n0, valid ? 1 : 0);
    if (valid) begin
      chk("R3 write bit", cap_w, kind[1]);
      chk("R3 type1 bit", cap_t1, kind[0]);
      chk("R3 bypass", cap_b, byp);
      chk("R3 address", cap_a, {ahi, alo});
      chk("R3 wdata", cap_d, wd);
      chk("R4 strobe", cap_s, is_rd ? 4'hF : sb);
    end
    ecode = !valid ? 3'd1 : (lat == 0 ? 3'd4 : code);
    if (is_rd) model_rdata = (ecode == 0) ? cd : 32'hFFFF_FFFF;
    rd(6'h04, v);
    chk("R5 status", v, {22'b0, ecode, 6'b0, 1'b1});
    rd(6'h18, v);
    chk(is_rd ? "R6 read data" : "R7 read data kept", v, model_rdata);
    rd(6'h20, v);
    chk("R5 done", v, 1);
    chk("R5 irq", irq_o, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [31:0] v;
    int n0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    for (int a = 0; a <= 8; a++) begin
      rd(6'(a * 4), v);
      chk("R1 reset reg", v, 0);
    end
    chk("R1 req_valid", req_valid_o, 0);
    chk("R1 irq", irq_o, 0);

    // R2 map / field masking / read-only
    wr(6'h00, 32'hFFFF_FFFF);
    rd(6'h00, v); chk("R2 ctrl mask", v, 32'h0100_000F);
    wr(6'h14, 32'hFFFF_FFFF);
    rd(6'h14, v); chk("R2 strobe mask", v, 32'h0000_000F);
    wr(6'h04, 32'hFFFF_FFFF);
    rd(6'h04, v); chk("R2 status read only", v, 0);
    wr(6'h18, 32'h1234_5678);
    rd(6'h18, v); chk("R2 rdata read only", v, 0);
    rd(6'h3C, v); chk("R2 unmapped", v, 0);
    chk("R2 no request", req_cnt, 0);

    // directed: successful type-0 read
    access(4'h8, 1'b1, cfg_addr(8'h00, 5'd0, 3'd0, 12'h010), 0, 0, 4'h0, 3, 3'd0, 32'hCAFE_0001);
    // R11 done write-0 ignored, write-1 clears
    wr(6'h20, 0);
    rd(6'h20, v); chk("R11 done write 0", v, 1);
    wr(6'h20, 1);
    rd(6'h20, v); chk("R11 done cleared", v, 0);
    chk("R11 irq cleared", irq_o, 0);

    // R6 read with retry code
    access(4'h9, 1'b0, cfg_addr(8'h05, 5'd3, 3'd1, 12'h100), 0, 0, 4'h0, 2, 3'd2, 32'h5555_5555);
    // R7 write: read data kept
    access(4'hA, 1'b0, cfg_addr(8'h01, 5'd0, 3'd0, 12'h004), 0, 32'h00AB_0000, lane_strb(2, 1), 4, 3'd0, 32'h0);

    // R9 invalid kinds
    access(4'h3, 1'b0, 32'h10, 0, 0, 4'h1, 2, 3'd0, 0);
    access(4'h4, 1'b0, 32'h10, 0, 0, 4'h1, 2, 3'd0, 0);

    // R8 timeout edge
    stub_lat = 0;
    wr(6'h20, 1);
    wr(6'h00, 32'h8);
    wr(6'h1C, 1);
    repeat (TO) @(negedge clk_i);
    rd(6'h1C, v); chk("R8 still busy before budget", v, 1);
    repeat (3) @(negedge clk_i);
    rd(6'h1C, v); chk("R8 ended after budget", v, 0);
    rd(6'h04, v); chk("R8 abort code", v, 32'h0000_0201);
    rd(6'h18, v); chk("R8 all-ones", v, 32'hFFFF_FFFF);
    model_rdata = 32'hFFFF_FFFF;

    // R10 writes ignored while busy
    stub_lat = 20; stub_code = 0; stub_data = 32'h0BAD_F00D;
    wr(6'h20, 1);
    wr(6'h00, 32'h9);
    wr(6'h08, 32'h0030_0008);
    n0 = req_cnt;
    wr(6'h1C, 1);
    wr(6'h00, 32'hA);
    wr(6'h08, 32'hDEAD_0000);
    wr(6'h14, 32'h3);
    wr(6'h1C, 0);
    rd(6'h1C, v); chk("R10 start kept", v, 1);
    wr(6'h1C, 1);
    repeat (25) @(negedge clk_i);
    chk("R10 single request", req_cnt - n0, 1);
    chk("R10 address unchanged", cap_a, 64'h0000_0000_0030_0008);
    rd(6'h00, v); chk("R10 ctrl unchanged", v, 32'h9);
    rd(6'h08, v); chk("R10 addr reg unchanged", v, 32'h0030_0008);
    rd(6'h18, v); chk("R5 read data", v, 32'h0BAD_F00D);
    model_rdata = 32'h0BAD_F00D;

    // random accesses
    for (int it = 0; it < 60; it++) begin
      logic [3:0] k;
      logic [2:0] c;
      int sz, off, r;
      k = 4'h8 + 4'($urandom_range(0, 3));
      r = $urandom_range(0, 5);
      c = (r < 3) ? 3'd0 : (r == 3) ? 3'd1 : (r == 4) ? 3'd2 : 3'd4;
      sz = 1 << $urandom_range(0, 2);
      off = (sz == 4) ? 0 : (sz == 2) ? 2 * $urandom_range(0, 1) : $urandom_range(0, 3);
      access(k, 1'($urandom_range(0, 1)),
             cfg_addr(8'($urandom), 5'($urandom), 3'($urandom), 12'($urandom)), 0,
             $urandom << (8 * off), lane_strb(off, sz), $urandom_range(1, 8), c, $urandom);
    end
    summary();
  end
endmodule